// File: doc/BRIEF.md
# AHB Read-Only Serial-Flash Window

This block is an AHB-Lite slave front end that presents an external serial flash as a read-only memory region. It decodes each address phase and turns an accepted read into a single word request on a simple downstream port. That port carries a word-aligned flash byte address with a valid/ready handshake and returns 32-bit data with a valid strobe. While the engine behind the port works, the block holds the bus in wait states. When the data arrives, the block completes the transfer.

A mode input selects between two modes. In memory-mapped mode the window is live. In command mode every access is answered locally and nothing reaches the flash side. Writes in memory-mapped mode are refused with the two-cycle ERROR response and have no side effect. A flash-size input, given as a base-two logarithm, limits the usable range. Reads past that range, and reads of the last word of the window, are answered locally with a fixed fill word (32'hA5A5_5A5A).

The controller is a seven-state machine:
- ST_IDLE: ready, no transfer in its data phase.
- ST_REQ: the request is offered downstream.
- ST_WAIT: the request was taken and the block waits for data.
- ST_DATA: the returned word is on HRDATA.
- ST_LOCAL: a zero-wait OKAY with the fill word.
- ST_ERR1 and ST_ERR2: the two ERROR cycles.

The transitions are as follows:
- A ready state (IDLE, DATA, LOCAL, ERR2) goes to REQ on a fetch, to LOCAL on a locally answered access, to ERR1 on a refused write, and otherwise to IDLE.
- REQ goes to WAIT on req_ready.
- WAIT goes to DATA on rsp_valid.
- ERR1 always goes to ERR2.

Top module: `sflash_ahb_window`

## Requirements
- R1: In memory-mapped mode (flash_mode=1), a write with HTRANS not IDLE gets HRESP=1 with HREADYOUT=0 for one cycle, then HRESP=1 with HREADYOUT=1. No downstream request is made.
- R2: In command mode (flash_mode=0), every accepted read or write completes with zero wait states, HRESP=0 and HRDATA=32'hA5A5_5A5A. No downstream request is made.
- R3: HTRANS NONSEQ (2'b10), SEQ (2'b11) and BUSY (2'b01) each start a new, separate downstream read.
- R4: req_addr equals HADDR minus BASE, with its two low bits cleared. The returned word is the four flash bytes starting at that aligned offset.
- R5: The last word of the 2^OFS_W window (offset 0x7FF_FFFC by default) is never forwarded. It is answered with zero waits, OKAY and the fill word. The word at 0x7FF_FFF8 is still forwarded.
- R6: A read at an offset of 2^size_log2 or above gets a zero-wait OKAY with the fill word and no request. Offsets below that limit are forwarded.
- R7: A transfer with HTRANS IDLE (2'b00), HSEL low or HREADY low starts no request. HREADYOUT stays 1 and HRESP stays 0.
- R8: For a forwarded read, HREADYOUT is 0 from the first data-phase cycle until rsp_valid is seen. In the next cycle, HRDATA holds rsp_data for one cycle, with HREADYOUT=1 and HRESP=0.
- R9: req_valid stays high and req_addr stays unchanged until req_ready is seen.
- R10: A low rst_n at a clock edge returns the block to idle, with HREADYOUT=1, HRESP=0 and req_valid=0.
- R11: A new address phase is accepted in the last cycle of the previous data phase (DATA, LOCAL or ERR2), with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flash_mode | input | 1 | 1 = memory-mapped window, 0 = command mode |
| size_log2 | input | SZ_W | Base-two log of the flash size in bytes |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Bus address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when 1 |
| hready | input | 1 | Bus-wide ready of the previous transfer |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | 1 = ERROR |
| hrdata | output | DATA_W | Read data |
| req_valid | output | 1 | Downstream read request valid |
| req_addr | output | OFS_W | Word-aligned flash byte address |
| req_ready | input | 1 | Downstream accepts the request |
| rsp_valid | input | 1 | Downstream data valid |
| rsp_data | input | DATA_W | Downstream data word |

## Verification
Two functions can fall in the same cycle: completing one data phase and accepting the next address phase. This happens in DATA, LOCAL or ERR2. The driver provokes it by issuing every transfer back to back, mixing fetches, refused writes and locally answered reads. A scoreboard monitor pops the expected response for each completed data phase and compares HRESP, HRDATA, the number of wait cycles and the running count of downstream handshakes. A response that leaks or lands on the wrong transfer therefore shows up as a mismatch.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DATA,
        ST_LOCAL,
        ST_ERR1,
        ST_ERR2
    } sfw_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_FETCH,
        ACT_LOCAL,
        ACT_ERROR
    } sfw_act_e;

    localparam logic [1:0] TR_IDLE = 2'b00;

endpackage

// File: rtl/sfw_addr_map.sv
module sfw_addr_map #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 27,
    parameter logic [ADDR_W-1:0] BASE = 32'h4000_0000,
    parameter int SZ_W   = $clog2(OFS_W + 1)
) (
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic [SZ_W-1:0]   size_log2_i,
    output logic [OFS_W-1:0]  word_addr_o,
    output logic              in_range_o
);

    logic [ADDR_W-1:0] diff;
    logic [OFS_W-1:0]  ofs;
    logic              outside;
    logic              past_size;
    logic              top_word;

    assign diff = haddr_i - BASE;
    assign ofs  = diff[OFS_W-1:0];

    generate
        if (ADDR_W > OFS_W) begin : g_wide
            assign outside = |diff[ADDR_W-1:OFS_W];
        end else begin : g_full
            assign outside = 1'b0;
        end
    endgenerate

    always_comb begin
        if (32'(size_log2_i) >= 32'(OFS_W)) begin
            past_size = 1'b0;
        end else begin
            past_size = |(ofs >> size_log2_i);
        end
        top_word    = &ofs[OFS_W-1:2];
        word_addr_o = {ofs[OFS_W-1:2], 2'b00};
        in_range_o  = !outside && !past_size && !top_word;
    end

endmodule

// File: rtl/sfw_decode.sv
module sfw_decode
    import sfw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       hsel_i,
    input  logic       hready_i,
    input  logic [1:0] htrans_i,
    input  logic       hwrite_i,
    input  logic       flash_mode_i,
    input  logic       in_range_i,
    output sfw_act_e   act_o
);

    always_comb begin
        act_o = ACT_NONE;
        if (hsel_i && hready_i && htrans_i != TR_IDLE) begin
            if (!flash_mode_i) begin
                act_o = ACT_LOCAL;
            end else if (hwrite_i) begin
                act_o = ACT_ERROR;
            end else if (in_range_i) begin
                act_o = ACT_FETCH;
            end else begin
                act_o = ACT_LOCAL;
            end
        end
    end

    AST_CMD_MODE_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flash_mode_i |-> act_o != ACT_FETCH && act_o != ACT_ERROR); // R2

    AST_QUIET_NO_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hsel_i || !hready_i || htrans_i == TR_IDLE) |-> act_o == ACT_NONE); // R7

endmodule

// File: rtl/sfw_ctrl.sv
module sfw_ctrl
    import sfw_pkg::*;
#(
    parameter int OFS_W  = 27,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] FILL = 32'hA5A5_5A5A
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  sfw_act_e          act_i,
    input  logic [OFS_W-1:0]  word_addr_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              hreadyout_o,
    output logic              hresp_o,
    output logic [DATA_W-1:0] hrdata_o,
    output logic              req_valid_o,
    output logic [OFS_W-1:0]  req_addr_o
);

    sfw_state_e        state_q, state_d;
    logic [OFS_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;
    logic              can_take;

    assign can_take = (state_q == ST_IDLE) || (state_q == ST_DATA) ||
                      (state_q == ST_LOCAL) || (state_q == ST_ERR2);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DATA, ST_LOCAL, ST_ERR2: begin
                unique case (act_i)
                    ACT_FETCH: state_d = ST_REQ;
                    ACT_LOCAL: state_d = ST_LOCAL;
                    ACT_ERROR: state_d = ST_ERR1;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_REQ:  state_d = req_ready_i ? ST_WAIT : ST_REQ;
            ST_WAIT: state_d = rsp_valid_i ? ST_DATA : ST_WAIT;
            ST_ERR1: state_d = ST_ERR2;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (can_take && act_i == ACT_FETCH) begin
                addr_q <= word_addr_i;
            end
            if (state_q == ST_WAIT && rsp_valid_i) begin
                data_q <= rsp_data_i;
            end
        end
    end

    always_comb begin
        hreadyout_o = 1'b1;
        hresp_o     = 1'b0;
        hrdata_o    = FILL;
        req_valid_o = 1'b0;
        req_addr_o  = addr_q;
        unique case (state_q)
            ST_REQ: begin
                hreadyout_o = 1'b0;
                req_valid_o = 1'b1;
            end
            ST_WAIT: hreadyout_o = 1'b0;
            ST_DATA: hrdata_o = data_q;
            ST_ERR1: begin
                hreadyout_o = 1'b0;
                hresp_o     = 1'b1;
            end
            ST_ERR2: hresp_o = 1'b1;
            default: ;
        endcase
    end

    AST_ERR_TWO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hresp_o && !hreadyout_o) |=> (hresp_o && hreadyout_o)); // R1

    AST_WRITE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (can_take && act_i == ACT_ERROR) |=> !req_valid_o); // R1

    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o))); // R9

    AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> req_addr_o[1:0] == 2'b00); // R4

    AST_TOP_WORD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> !(&req_addr_o[OFS_W-1:2])); // R5

    AST_RSP_DELIVERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WAIT && rsp_valid_i) |=>
            (hreadyout_o && !hresp_o && hrdata_o == $past(rsp_data_i))); // R8

    AST_RESET_IDLE: assert property (@(posedge clk_i)
        !rst_ni |=> (hreadyout_o && !hresp_o && !req_valid_o)); // R10

endmodule

// File: rtl/sflash_ahb_window.sv
module sflash_ahb_window
    import sfw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 27,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'h4000_0000,
    parameter logic [DATA_W-1:0] FILL = 32'hA5A5_5A5A,
    localparam int SZ_W  = $clog2(OFS_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_mode,
    input  logic [SZ_W-1:0]   size_log2,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata,
    output logic              req_valid,
    output logic [OFS_W-1:0]  req_addr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data
);

    logic [OFS_W-1:0] word_addr;
    logic             in_range;
    sfw_act_e         act;

    sfw_addr_map #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .BASE   (BASE),
        .SZ_W   (SZ_W)
    ) u_map (
        .haddr_i     (haddr),
        .size_log2_i (size_log2),
        .word_addr_o (word_addr),
        .in_range_o  (in_range)
    );

    sfw_decode u_dec (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .hsel_i       (hsel),
        .hready_i     (hready),
        .htrans_i     (htrans),
        .hwrite_i     (hwrite),
        .flash_mode_i (flash_mode),
        .in_range_i   (in_range),
        .act_o        (act)
    );

    sfw_ctrl #(
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W),
        .FILL   (FILL)
    ) u_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .act_i       (act),
        .word_addr_i (word_addr),
        .req_ready_i (req_ready),
        .rsp_valid_i (rsp_valid),
        .rsp_data_i  (rsp_data),
        .hreadyout_o (hreadyout),
        .hresp_o     (hresp),
        .hrdata_o    (hrdata),
        .req_valid_o (req_valid),
        .req_addr_o  (req_addr)
    );

endmodule

// File: tb/sflash_ahb_window_tb_top.sv
module sflash_ahb_window_tb_top;

    localparam int          OFS_W = 27;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam logic [31:0] FILL  = 32'hA5A5_5A5A;

    typedef struct {
        logic        resp;
        logic [31:0] data;
        int          waits;
        int          hs;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n, flash_mode, hsel, hwrite, hready_en, hready_in;
    logic [4:0]       size_log2;
    logic [31:0]      haddr, hrdata, rsp_data;
    logic [1:0]       htrans;
    logic             hreadyout, hresp, req_valid, req_ready, rsp_valid;
    logic [OFS_W-1:0] req_addr, resp_a;

    assign hready_in = hreadyout & hready_en;

    sflash_ahb_window dut_i (
        .clk(clk), .rst_n(rst_n), .flash_mode(flash_mode), .size_log2(size_log2),
        .hsel(hsel), .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hready(hready_in),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int   checks = 0, fails = 0, hs_cnt = 0, exp_hs = 0;
    int   ready_lag = 0, rsp_lat = 1;
    int   mon_waits = 0;
    bit   mon_dphase = 0, done = 0;
    exp_t q[$];

    function automatic logic [31:0] fmodel(input logic [OFS_W-1:0] a);
        return {a, 5'b0} ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // downstream responder model
    initial begin
        req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; resp_a = '0;
        forever begin
            @(negedge clk);
            if (req_valid === 1'b1) begin
                resp_a = req_addr;
                for (int i = 0; i < ready_lag; i++) begin
                    @(negedge clk);
                    chk(req_valid && req_addr == resp_a, "R9 request held until ready",
                        {5'b0, req_addr}, {5'b0, resp_a});
                end
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                hs_cnt++;
                for (int i = 0; i < rsp_lat; i++) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_data  = fmodel(resp_a);
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // monitor: pops expected items as data phases complete
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mon_dphase = 0;
            end else begin
                if (mon_dphase) begin
                    if (hreadyout) begin
                        exp_t e;
                        mon_dphase = 0;
                        if (q.size() == 0) begin
                            chk(1'b0, "R11 unexpected completion", 32'(hresp), 32'hFFFF_FFFF);
                        end else begin
                            e = q.pop_front();
                            chk(hresp == e.resp, $sformatf("%s hresp", e.tag), 32'(hresp), 32'(e.resp));
                            if (!e.resp)
                                chk(hrdata == e.data, $sformatf("%s hrdata", e.tag), hrdata, e.data);
                            if (e.waits < 0)
                                chk(mon_waits >= 1, $sformatf("%s R8 waits", e.tag), 32'(mon_waits), 32'd1);
                            else
                                chk(mon_waits == e.waits, $sformatf("%s waits", e.tag), 32'(mon_waits), 32'(e.waits));
                            chk(hs_cnt == e.hs, $sformatf("%s request count", e.tag), 32'(hs_cnt), 32'(e.hs));
                        end
                    end else begin
                        mon_waits++;
                    end
                end
                if (hsel && hready_in && htrans != 2'b00) begin
                    mon_dphase = 1;
                    mon_waits  = 0;
                end
            end
        end
    end

    // driver: kind 0 = fetch, 1 = local answer, 2 = error
    task automatic xfer(input logic [31:0] addr, input logic [1:0] tr, input logic wr,
                        input int kind, input string tag);
        exp_t        e;
        logic [31:0] d;
        d     = addr - BASE;
        e.tag = tag;
        e.hs  = exp_hs;
        e.resp = 1'b0; e.data = FILL; e.waits = 0;
        if (kind == 0) begin
            exp_hs++;
            e.hs    = exp_hs;
            e.data  = fmodel({d[OFS_W-1:2], 2'b00});
            e.waits = -1;
        end else if (kind == 2) begin
            e.resp  = 1'b1;
            e.waits = 1;
        end
        q.push_back(e);
        haddr = addr; htrans = tr; hwrite = wr; hsel = 1'b1;
        do @(negedge clk); while (!hready_in);
        @(posedge clk); #2;
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic quiet_check(input string tag);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(hreadyout && !hresp, $sformatf("%s ready/okay", tag), {30'b0, hreadyout, hresp}, 32'h2);
        end
        chk(hs_cnt == exp_hs, $sformatf("%s no request", tag), 32'(hs_cnt), 32'(exp_hs));
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; flash_mode = 1'b1; size_log2 = 5'd27; hsel = 1'b0; haddr = BASE;
        htrans = 2'b00; hwrite = 1'b0; hready_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hreadyout && !hresp && !req_valid, "R10 reset state",
            {29'b0, hreadyout, hresp, req_valid}, 32'h4);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R3 R4 R8 R11: back-to-back reads of each active transfer type
        xfer(BASE + 32'h0,     2'b10, 1'b0, 0, "R3 R4 NONSEQ word 0");
        xfer(BASE + 32'h7,     2'b11, 1'b0, 0, "R3 R4 SEQ unaligned");
        xfer(BASE + 32'h1234,  2'b01, 1'b0, 0, "R3 BUSY read");
        // R1 R11: refused write between reads
        xfer(BASE + 32'h40,    2'b10, 1'b1, 2, "R1 write error");
        xfer(BASE + 32'h44,    2'b10, 1'b0, 0, "R11 read after error");
        xfer(BASE + 32'h48,    2'b11, 1'b1, 2, "R1 SEQ write error");
        xfer(BASE + 32'h48,    2'b11, 1'b1, 2, "R1 repeated error");
        // R5: window top boundary
        xfer(BASE + 32'h7FF_FFF8, 2'b10, 1'b0, 0, "R5 last usable word");
        xfer(BASE + 32'h7FF_FFFC, 2'b10, 1'b0, 1, "R5 top word local");
        xfer(BASE + 32'h10,    2'b10, 1'b0, 0, "R11 read after local");
        drain();

        // R9: slow downstream handshake
        ready_lag = 3; rsp_lat = 4;
        xfer(BASE + 32'h2468,  2'b10, 1'b0, 0, "R9 R8 slow port");
        drain();
        ready_lag = 0; rsp_lat = 0;
        xfer(BASE + 32'h100,   2'b10, 1'b0, 0, "R8 fast port");
        drain();

        // R6: flash size 1 MB
        size_log2 = 5'd20;
        xfer(BASE + 32'h10_0000, 2'b10, 1'b0, 1, "R6 beyond size");
        xfer(BASE + 32'h0F_FFFC, 2'b10, 1'b0, 0, "R6 last in size");
        xfer(BASE + 32'h40_0000, 2'b11, 1'b0, 1, "R6 far beyond size");
        drain();
        size_log2 = 5'd27;

        // R2: command mode
        flash_mode = 1'b0;
        xfer(BASE + 32'h20,    2'b10, 1'b0, 1, "R2 command read");
        xfer(BASE + 32'h24,    2'b10, 1'b1, 1, "R2 command write");
        xfer(BASE + 32'h28,    2'b01, 1'b0, 1, "R2 command busy");
        drain();
        flash_mode = 1'b1;

        // R7: transfers that must be ignored
        hsel = 1'b0; htrans = 2'b10; haddr = BASE + 32'h30;
        quiet_check("R7 hsel low");
        hsel = 1'b1; htrans = 2'b00;
        quiet_check("R7 htrans idle");
        hready_en = 1'b0; htrans = 2'b10;
        quiet_check("R7 hready low");
        hsel = 1'b0; htrans = 2'b00; hready_en = 1'b1;

        xfer(BASE + 32'h30,    2'b10, 1'b0, 0, "R3 read after ignored");
        drain();
        chk(hs_cnt == exp_hs, "R3 total requests", 32'(hs_cnt), 32'(exp_hs));
        chk(q.size() == 0, "R8 scoreboard drained", 32'(q.size()), 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule